// File: doc/BRIEF.md
# CRC Convention Finder

This block identifies which 32-bit CRC convention a link uses. A packet whose check word is known to be good is streamed through it one byte at a time, together with that check word. The block evaluates the same generator polynomial under every combination of five conventions at once: starting register value, the order in which bits are taken from each byte, bit reversal of the result, byte reversal of the result, and inversion of the result. When the packet ends it reports every combination that reproduced the check word.

The 32 combinations are called lanes, and a lane number encodes the five choices as one bit each. Only the starting value and the bit order change the running register. The block therefore keeps four running registers and derives all 32 lane results from them by rewiring and inversion. More than one lane can agree with the check word. The block reports all of them as a mask, plus a single preferred choice: the lowest lane number that matched.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` rises in the first cycle after reset and stays high. A byte is taken on every rising clock edge where `in_valid` and `in_ready` are both high. The result pins are plain status outputs with a one-cycle strobe.

Top module: `crc_variant_scan`

## Requirements
- R1: Reset state: `res_valid` is low, and `res_mask`, `res_found` and `res_index` are all zero.
- R2: Lane number bits select the conventions. Bit 0: start value (0 = all zeros, 1 = `INIT_ALT`, default all ones). Bit 1: input order (0 = byte bit 0 first, 1 = byte bit 7 first). Bit 2: result bits mirrored (bit k goes to bit 31-k). Bit 3: result bytes swapped (byte 0 with byte 3, byte 1 with byte 2). Bit 4: result inverted. Mirroring and swapping are applied before inversion.
- R3: For each input bit, the register shifts left by one. The value 0x04C11DB7 is XORed in when the old bit 31 differs from the input bit. Known answer: the ASCII bytes "123456789" with check word 0xCBF43926 set mask bit 21, and with check word 0x2639F4CB set mask bit 29.
- R4: `res_valid` pulses high for exactly one cycle, in the cycle after the byte carrying `in_last` is accepted. The result outputs hold their values until the next such pulse.
- R5: `res_mask` bit n is 1 exactly when lane n's result, computed over the whole packet, equals `in_expect` as sampled with the last byte.
- R6: `res_found` is the OR of the mask. `res_index` is the lowest set mask bit, or 0 when no bit is set.
- R7: The first accepted byte after a last byte (or after reset) restarts every lane from its own start value, so earlier packets do not affect the result.
- R8: Cycles in which `in_valid` is low change no lane state, whatever the data, last and expect pins carry.
- R9: `in_ready` is high in every cycle after the first cycle out of reset.
- R10: Two lanes that differ only in lane bit 4 never both match in the same result.
- R11: A packet of a single byte, with `in_last` set on its only byte, produces a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Block accepts a byte (always high out of reset) |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | This byte ends the packet |
| in_expect | input | 32 | Known-good check word, sampled with the last byte |
| res_valid | output | 1 | One-cycle strobe: a new result is present |
| res_mask | output | 32 | One bit per lane: that lane reproduced the check word |
| res_found | output | 1 | At least one lane matched |
| res_index | output | 5 | Lowest matching lane number |

## Verification
The hardest outcome to reach from the ports is a result where several lanes agree, or where exactly one rare lane agrees. Random packets almost never reproduce a check word by chance. The stimulus therefore often takes the check word from a bench model of a chosen lane. It also sends all-zero packets, where every lane with a zero start value and no inversion matches at once. Random idle gaps with garbage on the data, last and expect pins are placed between bytes. Packets are also sent back to back and as single bytes, to test the restart at a packet boundary.

// File: rtl/crcv_pkg.sv
package crcv_pkg;
  localparam int CRC_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = CRC_W / BYTE_W;
  localparam int AXES    = 5;
  localparam int LANES   = 1 << AXES;
  localparam int IDX_W   = AXES;
  localparam int CORE_AXES = 2;
  localparam int CORES   = 1 << CORE_AXES;

  // bit positions of the conventions inside a lane number
  localparam int AX_INIT    = 0;
  localparam int AX_MSB_IN  = 1;
  localparam int AX_BITREV  = 2;
  localparam int AX_BYTEREV = 3;
  localparam int AX_INVERT  = 4;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  lane_idx_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  // one byte through the serial shift register, unrolled over its bits
  function automatic crc_t crc_feed_byte(crc_t c, byte_t d, logic msb_first, crc_t poly);
    crc_t r;
    logic b;
    r = c;
    for (int k = 0; k < BYTE_W; k++) begin
      b = msb_first ? d[BYTE_W-1-k] : d[k];
      if (r[CRC_W-1] ^ b) r = (r << 1) ^ poly;
      else                r = r << 1;
    end
    return r;
  endfunction

  function automatic crc_t crc_mirror(crc_t c);
    crc_t r;
    for (int k = 0; k < CRC_W; k++) r[k] = c[CRC_W-1-k];
    return r;
  endfunction

  function automatic crc_t crc_swap_bytes(crc_t c);
    crc_t r;
    for (int k = 0; k < N_BYTES; k++)
      r[k*BYTE_W +: BYTE_W] = c[(N_BYTES-1-k)*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/crcv_core.sv
module crcv_core
  import crcv_pkg::*;
#(
  parameter crc_t POLY      = 32'h04C1_1DB7,
  parameter crc_t START     = '0,
  parameter bit   MSB_FIRST = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  restart,
  input  byte_t data,
  output crc_t  state_nxt
);
  crc_t state;
  crc_t base;

  always_comb begin
    base      = restart ? START : state;
    state_nxt = take ? crc_feed_byte(base, data, MSB_FIRST, POLY) : state;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= START;
    else        state <= state_nxt;
  end

  // R8: an idle cycle leaves the running register untouched
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(state));
endmodule

// File: rtl/crcv_lane.sv
module crcv_lane
  import crcv_pkg::*;
#(
  parameter bit BITREV  = 1'b0,
  parameter bit BYTEREV = 1'b0,
  parameter bit INVERT  = 1'b0
) (
  input  crc_t raw,
  input  crc_t expect_word,
  output logic hit
);
  crc_t shaped_a;
  crc_t shaped_b;
  crc_t shaped;

  generate
    if (BITREV) begin : g_mirror
      assign shaped_a = crc_mirror(raw);
    end else begin : g_straight
      assign shaped_a = raw;
    end
    if (BYTEREV) begin : g_swap
      assign shaped_b = crc_swap_bytes(shaped_a);
    end else begin : g_keep
      assign shaped_b = shaped_a;
    end
    if (INVERT) begin : g_inv
      assign shaped = ~shaped_b;
    end else begin : g_pass
      assign shaped = shaped_b;
    end
  endgenerate

  assign hit = (shaped == expect_word);
endmodule

// File: rtl/crcv_pick.sv
module crcv_pick
  import crcv_pkg::*;
(
  input  lane_mask_t mask,
  output logic       found,
  output lane_idx_t  index
);
  always_comb begin
    found = |mask;
    index = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (mask[i]) index = i[IDX_W-1:0];
  end
endmodule

// File: rtl/crc_variant_scan.sv
module crc_variant_scan
  import crcv_pkg::*;
#(
  parameter crc_t POLY     = 32'h04C1_1DB7,
  parameter crc_t INIT_ALT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [31:0] in_expect,
  output logic        res_valid,
  output logic [31:0] res_mask,
  output logic        res_found,
  output logic [4:0]  res_index
);
  logic       accept;
  logic       fresh;
  crc_t       core_nxt [CORES];
  lane_mask_t hit_vec;
  logic       pick_found;
  lane_idx_t  pick_index;

  assign accept = in_valid && in_ready;

  generate
    for (genvar c = 0; c < CORES; c++) begin : g_core
      crcv_core #(
        .POLY      (POLY),
        .START     (((c >> AX_INIT) & 1) != 0 ? INIT_ALT : '0),
        .MSB_FIRST (((c >> AX_MSB_IN) & 1) != 0)
      ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .restart   (fresh),
        .data      (in_data),
        .state_nxt (core_nxt[c])
      );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      crcv_lane #(
        .BITREV  (((l >> AX_BITREV) & 1) != 0),
        .BYTEREV (((l >> AX_BYTEREV) & 1) != 0),
        .INVERT  (((l >> AX_INVERT) & 1) != 0)
      ) i_lane (
        .raw         (core_nxt[l % CORES]),
        .expect_word (in_expect),
        .hit         (hit_vec[l])
      );
    end
  endgenerate

  crcv_pick i_pick (
    .mask  (hit_vec),
    .found (pick_found),
    .index (pick_index)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      fresh     <= 1'b1;
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_found <= 1'b0;
      res_index <= '0;
    end else begin
      in_ready  <= 1'b1;
      res_valid <= accept && in_last;
      if (accept) fresh <= in_last;
      if (accept && in_last) begin
        res_mask  <= hit_vec;
        res_found <= pick_found;
        res_index <= pick_index;
      end
    end
  end

  // R4: strobe follows an accepted last byte and nothing else
  assert_strobe_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready && in_last));
  assert_last_gives_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> res_valid);
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_mask) && $stable(res_index) && $stable(res_found)));

  // R6: index names the lowest set lane of the mask
  assert_lowest_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_found |-> (res_mask[res_index] &&
                   ((res_mask & ~({LANES{1'b1}} << res_index)) == '0)));
  assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_found |-> (res_mask == '0 && res_index == '0));

  // R10: inverted and plain versions of one lane cannot both equal one word
  generate
    for (genvar p = 0; p < LANES / 2; p++) begin : g_excl
      assert_invert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_mask[p] && res_mask[p + LANES/2]));
    end
  endgenerate
endmodule

// File: tb/test_crc_variant_scan.sv
module test_crc_variant_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [31:0] in_expect = '0;
  logic        res_valid;
  logic [31:0] res_mask;
  logic        res_found;
  logic [4:0]  res_index;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] pkt [64];

  always #5 clk = ~clk;

  crc_variant_scan i_crc_variant_scan (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_expect(in_expect),
    .res_valid(res_valid), .res_mask(res_mask), .res_found(res_found),
    .res_index(res_index));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // lane value per R2 and R3, computed serially from the packet buffer
  function automatic logic [31:0] model(int lane, int n);
    logic [31:0] c, r;
    logic b;
    c = ((lane & 1) != 0) ? 32'hFFFF_FFFF : 32'h0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        b = ((lane & 2) != 0) ? pkt[i][7-k] : pkt[i][k];
        if (c[31] ^ b) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
        else           c = {c[30:0], 1'b0};
      end
    if ((lane & 4) != 0) begin
      for (int k = 0; k < 32; k++) r[k] = c[31-k];
      c = r;
    end
    if ((lane & 8) != 0) c = {c[7:0], c[15:8], c[23:16], c[31:24]};
    if ((lane & 16) != 0) c = ~c;
    return c;
  endfunction

  function automatic logic [31:0] model_mask(int n, logic [31:0] exp);
    logic [31:0] m;
    for (int l = 0; l < 32; l++) m[l] = (model(l, n) == exp);
    return m;
  endfunction

  task automatic send_pkt(input int n, input logic [31:0] exp, input int gap_max, input string tag);
    logic [31:0] em;
    logic [4:0]  ei;
    logic [31:0] held;
    em = model_mask(n, exp);
    ei = '0;
    for (int l = 31; l >= 0; l--) if (em[l]) ei = l[4:0];
    for (int i = 0; i < n; i++) begin
      int gaps;
      gaps = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
      for (int g = 0; g < gaps; g++) begin
        in_valid  = 1'b0;
        in_data   = $urandom;
        in_last   = $urandom;
        in_expect = $urandom;
        @(negedge clk);
      end
      in_valid  = 1'b1;
      in_data   = pkt[i];
      in_last   = (i == n - 1);
      in_expect = (i == n - 1) ? exp : $urandom;
      @(negedge clk);
      if (i != n - 1)
        chk(res_valid == 1'b0, {tag, " R4 no strobe mid packet"}, res_valid, 0);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(res_valid == 1'b1, {tag, " R4 strobe after last"}, res_valid, 1);
    chk(res_mask == em, {tag, " R5 mask"}, res_mask, em);
    chk(res_found == (em != 0), {tag, " R6 found"}, res_found, em != 0);
    chk(res_index == ei, {tag, " R6 index"}, res_index, ei);
    held = res_mask;
    @(negedge clk);
    chk(res_valid == 1'b0 && res_mask == held, {tag, " R4 single pulse and hold"},
        {res_valid, res_mask}, {1'b0, held});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R4 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    void'($urandom(32'h5EED_0C2C));
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk(res_valid == 0 && res_mask == 0 && res_found == 0 && res_index == 0,
        "R1 reset state", {res_valid, res_found, res_index, res_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    chk(res_valid == 0 && res_mask == 0 && res_found == 0,
        "R1 state after reset", {res_valid, res_found, res_mask}, 0);

    // R3 / R2 known answers on "123456789"
    for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + i[7:0];
    send_pkt(9, 32'hCBF4_3926, 0, "R3 known answer mirrored");
    chk(res_mask[21] == 1'b1, "R2 lane 21 selected", res_mask, 32'h0020_0000);
    send_pkt(9, 32'h2639_F4CB, 2, "R3 known answer swapped");
    chk(res_mask[29] == 1'b1, "R2 lane 29 selected", res_mask, 32'h2000_0000);

    // R6: all-zero packet, every zero-start non-inverted lane agrees
    for (int i = 0; i < 6; i++) pkt[i] = 8'h00;
    send_pkt(6, 32'h0, 1, "R6 multi match");
    chk(res_mask == 32'h0000_5555, "R6 zero packet mask", res_mask, 32'h0000_5555);

    // R11: single-byte packets
    pkt[0] = 8'hA5;
    send_pkt(1, model(18, 1), 0, "R11 single byte");
    pkt[0] = 8'h01;
    send_pkt(1, model(31, 1), 0, "R11 single byte high lane");

    // R8: long idle with garbage on the pins, then a packet
    for (int g = 0; g < 20; g++) begin
      in_valid = 1'b0; in_data = $urandom; in_last = $urandom; in_expect = $urandom;
      @(negedge clk);
    end
    for (int i = 0; i < 12; i++) pkt[i] = $urandom;
    send_pkt(12, model(7, 12), 3, "R8 after idle");

    // R7 / R5: random packets, back to back and with gaps
    for (int t = 0; t < 60; t++) begin
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) pkt[i] = $urandom;
      if (t % 4 == 3) send_pkt(n, $urandom, 0, "R7 random no match");
      else send_pkt(n, model(int'($urandom % 32), n), (t % 2) * 3, "R7 random lane");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule